// File: doc/BRIEF.md
# Power Fault History Latch Unit

This block keeps a two-entry history of power failures. When a fault strobe arrives, it stores the cause in a present record. The cause is made of a fault type, the filter assembly involved and the failing supply. Only the first valid strobe after the present record was emptied is kept, so later fault noise cannot overwrite the original cause. The record persists while the mainline enable input stays high, no matter what the power-on input does.

A transfer event is the rising of the combination reset key AND power-on. On that event the present record moves into a previous record, and the present record is cleared. Capture is then armed again, so the block holds the cause of the current failure and the cause of the one before it.

A selector and a display key choose which record drives an 8-bit display byte. This works even while power-on is low, so a field engineer can read either record while main power is down. The display byte is registered and is all zeros whenever the key is released.

Top module: `pwr_fault_history`

## Requirements
- R1: After rst_n is asserted, both records are zero and disp_byte reads 0x00.
- R2: The present record captures {fault_kind, filter_code, supply_code} on a clock edge when all of these hold: fault_strobe is high, mainline_on is high, the present record is empty, fault_kind is not 00 and no transfer is happening. The capture is visible on the display one cycle after that edge.
- R3: While the present record holds a capture, further fault strobes leave it unchanged.
- R4: A fault strobe with fault_kind equal to 00 (no failure) is ignored and leaves the present record empty.
- R5: A transfer fires on the first clock edge that samples reset_key, power_on and mainline_on all high after any of them was low. It copies the present record into the previous record, clears the present record to zero and re-arms capture. Holding the combination high causes no further transfers.
- R6: A fault strobe sampled on the same edge as a transfer is dropped, and the present record ends up empty.
- R7: While mainline_on is low, both records are cleared, and strobes and transfers have no effect.
- R8: disp_byte[7:6] is the fault type (01 undervoltage, 10 overvoltage, 11 overcurrent). disp_byte[5:4] is the filter assembly (01 multilevel, 11 dual-level). disp_byte[3:0] is the supply (0001..1001 = -4V, +5V, -5V, +6V, +8.5V, +12V, -12V, +24V, -24V; 1111 = several levels failing).
- R9: With disp_key high, disp_byte shows the present record when sel_prev is 0 and the previous record when sel_prev is 1, one cycle after the selection is sampled.
- R10: With disp_key low, disp_byte is 0x00 one cycle later.
- R11: The display works the same with power_on low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mainline_on | input | 1 | Mainline enable; records are kept only while it is high |
| power_on | input | 1 | Main power is up |
| reset_key | input | 1 | Operator reset key |
| fault_strobe | input | 1 | A power fault was detected this cycle |
| fault_kind | input | 2 | Fault type code |
| filter_code | input | 2 | Filter assembly code |
| supply_code | input | 4 | Failing supply code |
| sel_prev | input | 1 | 0 selects the present record, 1 selects the previous record |
| disp_key | input | 1 | Display request key |
| disp_byte | output | 8 | Registered display byte |

## Verification
The bench sweeps all 256 combinations of the three fault fields. Each combination goes through capture, transfer and the two displays. A wrong field order would show up as swapped display bits. A design that latches kind-00 strobes would show a non-zero present record.

Re-strobing after a capture checks that the first cause is kept rather than the last one. A strobe on the same edge as a transfer checks that the present record is not left holding a stale fault. Holding the reset key down across several cycles catches a level-triggered transfer, which would wipe the previous record. Dropping mainline_on checks that both records are lost, and the power-off display check catches a display wrongly gated by power_on.

// File: rtl/pfh_pkg.sv
package pfh_pkg;
  localparam int KIND_W   = 2;
  localparam int FILT_W   = 2;
  localparam int SUPPLY_W = 4;
  localparam int REC_W    = KIND_W + FILT_W + SUPPLY_W;

  typedef struct packed {
    logic [KIND_W-1:0]   kind;
    logic [FILT_W-1:0]   filt;
    logic [SUPPLY_W-1:0] supply;
  } fault_rec_t;

  localparam fault_rec_t REC_EMPTY = '0;
endpackage

// File: rtl/pfh_event_detect.sv
module pfh_event_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic mainline_on,
  input  logic reset_key,
  input  logic power_on,
  output logic xfer
);
  logic ev_lvl;
  logic ev_q;

  assign ev_lvl = reset_key & power_on & mainline_on;
  assign xfer   = ev_lvl & ~ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= ev_lvl;
  end

  // R5: a held combination yields exactly one transfer pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
endmodule

// File: rtl/pfh_present.sv
module pfh_present
  import pfh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mainline_on,
  input  logic       xfer,
  input  logic       strobe,
  input  fault_rec_t rec_in,
  output fault_rec_t pres_rec
);
  logic held;
  logic accept;

  assign accept = mainline_on && !xfer && strobe && !held &&
                  (rec_in.kind != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_rec <= REC_EMPTY;
      held     <= 1'b0;
    end else if (!mainline_on || xfer) begin
      pres_rec <= REC_EMPTY;
      held     <= 1'b0;
    end else if (accept) begin
      pres_rec <= rec_in;
      held     <= 1'b1;
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mainline_on && !xfer && strobe && !held && rec_in.kind != '0)
    |=> pres_rec == $past(rec_in));
  a_r3_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held && mainline_on && !xfer) |=> $stable(pres_rec));
  a_r4_no_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && rec_in.kind == '0) |=> !held);
  a_r6_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (pres_rec == REC_EMPTY && !held));
  a_r7_mainline_pres: assert property (@(posedge clk) disable iff (!rst_n)
    !mainline_on |=> pres_rec == REC_EMPTY);
endmodule

// File: rtl/pfh_previous.sv
module pfh_previous
  import pfh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mainline_on,
  input  logic       xfer,
  input  fault_rec_t pres_rec,
  output fault_rec_t prev_rec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            prev_rec <= REC_EMPTY;
    else if (!mainline_on) prev_rec <= REC_EMPTY;
    else if (xfer)         prev_rec <= pres_rec;
  end

  a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mainline_on) |=> prev_rec == $past(pres_rec));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && mainline_on) |=> $stable(prev_rec));
  a_r7_mainline_prev: assert property (@(posedge clk) disable iff (!rst_n)
    !mainline_on |=> prev_rec == REC_EMPTY);
endmodule

// File: rtl/pfh_display.sv
module pfh_display
  import pfh_pkg::*;
#(
  parameter int OUT_W = REC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_key,
  input  logic             sel_prev,
  input  fault_rec_t       pres_rec,
  input  fault_rec_t       prev_rec,
  output logic [OUT_W-1:0] disp_byte
);
  logic [OUT_W-1:0] chosen;

  always_comb begin
    if (!disp_key)     chosen = '0;
    else if (sel_prev) chosen = OUT_W'(prev_rec);
    else               chosen = OUT_W'(pres_rec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_byte <= '0;
    else        disp_byte <= chosen;
  end

  a_r9_present: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_key && !sel_prev) |=> disp_byte == OUT_W'($past(pres_rec)));
  a_r9_previous: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_key && sel_prev) |=> disp_byte == OUT_W'($past(prev_rec)));
  a_r10_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_key |=> disp_byte == '0);
endmodule

// File: rtl/pwr_fault_history.sv
module pwr_fault_history
  import pfh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mainline_on,
  input  logic                power_on,
  input  logic                reset_key,
  input  logic                fault_strobe,
  input  logic [KIND_W-1:0]   fault_kind,
  input  logic [FILT_W-1:0]   filter_code,
  input  logic [SUPPLY_W-1:0] supply_code,
  input  logic                sel_prev,
  input  logic                disp_key,
  output logic [REC_W-1:0]    disp_byte
);
  logic       xfer;
  fault_rec_t rec_in;
  fault_rec_t pres_rec;
  fault_rec_t prev_rec;

  assign rec_in = '{kind: fault_kind, filt: filter_code, supply: supply_code};

  pfh_event_detect u_event (
    .clk(clk), .rst_n(rst_n), .mainline_on(mainline_on),
    .reset_key(reset_key), .power_on(power_on), .xfer(xfer)
  );

  pfh_present u_present (
    .clk(clk), .rst_n(rst_n), .mainline_on(mainline_on), .xfer(xfer),
    .strobe(fault_strobe), .rec_in(rec_in), .pres_rec(pres_rec)
  );

  pfh_previous u_previous (
    .clk(clk), .rst_n(rst_n), .mainline_on(mainline_on), .xfer(xfer),
    .pres_rec(pres_rec), .prev_rec(prev_rec)
  );

  pfh_display #(.OUT_W(REC_W)) u_display (
    .clk(clk), .rst_n(rst_n), .disp_key(disp_key), .sel_prev(sel_prev),
    .pres_rec(pres_rec), .prev_rec(prev_rec), .disp_byte(disp_byte)
  );

  // R8: field placement on the display byte
  a_r8_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_key && !sel_prev) |=>
      disp_byte == {$past(pres_rec.kind), $past(pres_rec.filt), $past(pres_rec.supply)});
  // R1 is covered through reset values checked by the bench
endmodule

// File: tb/pwr_fault_history_test.sv
`timescale 1ns/1ps
module pwr_fault_history_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mainline_on = 1'b0;
  logic       power_on = 1'b0;
  logic       reset_key = 1'b0;
  logic       fault_strobe = 1'b0;
  logic [1:0] fault_kind = '0;
  logic [1:0] filter_code = '0;
  logic [3:0] supply_code = '0;
  logic       sel_prev = 1'b0;
  logic       disp_key = 1'b0;
  logic [7:0] disp_byte;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_fault_history uut (
    .clk(clk), .rst_n(rst_n), .mainline_on(mainline_on), .power_on(power_on),
    .reset_key(reset_key), .fault_strobe(fault_strobe), .fault_kind(fault_kind),
    .filter_code(filter_code), .supply_code(supply_code), .sel_prev(sel_prev),
    .disp_key(disp_key), .disp_byte(disp_byte)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] v);
    {fault_kind, filter_code, supply_code} = v;
    fault_strobe = 1'b1;
    tick();
    fault_strobe = 1'b0;
  endtask

  task automatic transfer();
    reset_key = 1'b1;
    tick();
    reset_key = 1'b0;
    tick();
  endtask

  task automatic show(input logic prev, output logic [7:0] val);
    disp_key = 1'b1;
    sel_prev = prev;
    tick();
    val = disp_byte;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    tick();
    // R1: reset state
    check("R1 reset display", disp_byte, 8'h00);
    rst_n = 1'b1;
    mainline_on = 1'b1;
    power_on = 1'b1;
    tick();
    show(1'b0, v); check("R1 present empty", v, 8'h00);
    show(1'b1, v); check("R1 previous empty", v, 8'h00);

    // R2 R3 R4 R5 R8 R9: sweep all field combinations
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      e = (i / 64 == 0) ? 8'h00 : 8'(i);
      transfer();
      strobe(8'(i));
      show(1'b0, v);
      check((i / 64 == 0) ? "R4 kind 00 ignored" : "R2 R8 capture", v, e);
      if (e != 8'h00) begin
        strobe(8'(255 - i) | 8'h40);
        show(1'b0, v); check("R3 first kept", v, e);
      end
      transfer();
      show(1'b1, v); check("R5 R9 previous", v, e);
      show(1'b0, v); check("R5 present cleared", v, 8'h00);
    end

    // R6: strobe on the transfer edge is dropped
    strobe(8'h95);
    {fault_kind, filter_code, supply_code} = 8'hE2;
    fault_strobe = 1'b1; reset_key = 1'b1;
    tick();
    fault_strobe = 1'b0; reset_key = 1'b0;
    tick();
    show(1'b0, v); check("R6 present empty", v, 8'h00);
    show(1'b1, v); check("R6 previous", v, 8'h95);

    // R5: held combination transfers once
    strobe(8'h51);
    reset_key = 1'b1;
    tick(); tick();
    strobe(8'hF3);
    tick(); tick();
    reset_key = 1'b0;
    tick();
    show(1'b0, v); check("R5 held no re-transfer present", v, 8'hF3);
    show(1'b1, v); check("R5 held no re-transfer previous", v, 8'h51);

    // R11: display with power down
    power_on = 1'b0;
    show(1'b0, v); check("R11 present power down", v, 8'hF3);
    show(1'b1, v); check("R11 previous power down", v, 8'h51);
    transfer();
    show(1'b1, v); check("R11 no transfer without power", v, 8'h51);
    power_on = 1'b1;

    // R10: key released blanks display
    disp_key = 1'b0;
    tick();
    check("R10 blank", disp_byte, 8'h00);

    // R7: mainline off clears both and ignores strobes
    mainline_on = 1'b0;
    tick();
    strobe(8'h66);
    transfer();
    mainline_on = 1'b1;
    tick();
    show(1'b0, v); check("R7 present cleared", v, 8'h00);
    show(1'b1, v); check("R7 previous cleared", v, 8'h00);
    strobe(8'hA7);
    show(1'b0, v); check("R7 capture after restore", v, 8'hA7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule